// File: doc/BRIEF.md
# Port Bus Width Adapter with Lane Reordering

This block sits between a 36-bit internal datapath and an external port whose width can be set to 36, 18 or 9 bits while the design runs. The internal word is made of four 9-bit lanes L3..L0, each holding 8 data bits and a parity bit. The adapter passes the parity bits through unchanged and does not check or generate them. On the inbound side, narrow transfers are collected into one internal word. On the outbound side, an internal word is handed out as one long word, two halves or four bytes, one part per enabled clock.

Two controls set the part order. The endian select decides whether the most or the least significant part moves first. The lane-swap mode reorders the four lanes between the port and the internal word. The width, endian and swap controls are taken directly from the inputs on the first transfer of a word. They are then held inside the block until that word is complete, and each direction holds its own copy. Everything runs on one free-running port clock. Each transfer happens on a rising edge where the direction's enable is high.

Top module: `port_width_adapter`

## Requirements
- R1: While rst_n is low, pk_valid is 0 and pk_word is 0. When rd_en is 0, rd_next is 0. After reset, both directions start at the first part of a word.
- R2: With cfg_size 2'b00 (long word; 2'b11 acts the same), every write transfer completes a word. rd_data presents the whole reordered rd_word.
- R3: With cfg_size 2'b01 (18-bit), a word takes two transfers on bits [17:0]. With cfg_big=1 the upper half (lanes 3..2) moves first; with cfg_big=0 the lower half moves first.
- R4: With cfg_size 2'b10 (9-bit), a word takes four transfers on bits [8:0]. With cfg_big=1 the order is lanes 3,2,1,0; with cfg_big=0 it is lanes 0,1,2,3.
- R5: cfg_swap picks the lane order of the port-side word relative to the internal word {L3,L2,L1,L0}. The codes are: 00 keeps it; 01 gives {L0,L1,L2,L3}; 10 gives {L1,L0,L3,L2}; 11 gives {L2,L3,L0,L1}. The same mapping applies in both directions.
- R6: pk_valid pulses for one cycle, in the cycle after the edge that took the last part of a word, and pk_word then holds the assembled word. rd_next is high in the cycle where rd_en takes the last part. Cycles with the enable low neither advance nor complete a word.
- R7: Changes to cfg_size, cfg_big or cfg_swap after the first part of a word has moved do not affect that word.
- R8: In the 18-bit and 9-bit sizes, the rd_data bits above the active width are 0.
- R9: In the 18-bit and 9-bit sizes, the wr_data bits above the active width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 2 | Port width: 00 long, 01 18-bit, 10 9-bit, 11 long |
| cfg_big | input | 1 | 1: most significant part first |
| cfg_swap | input | 2 | Lane reorder mode |
| wr_en | input | 1 | Inbound transfer enable |
| wr_data | input | 36 | Inbound port data, narrow parts on the low bits |
| pk_valid | output | 1 | One-cycle pulse: assembled word ready |
| pk_word | output | 36 | Assembled internal word |
| rd_word | input | 36 | Internal word to send, held until rd_next |
| rd_en | input | 1 | Outbound transfer enable |
| rd_data | output | 36 | Outbound port data |
| rd_next | output | 1 | Last part of rd_word taken this cycle |

## Verification
A wrong part counter shows up right away. On the read side, rd_data shows the wrong lane and rd_next appears on the wrong transfer. On the write side, pk_valid pulses one cycle too early or too late, and the wrong lanes land in pk_word. A config register that tracks the inputs in the middle of a word corrupts that word, which is visible at pk_word on its completion strobe or in the next rd_data part. The bench sweeps every size, endian and swap code, and changes the controls in the middle of words, so these faults show up within a few cycles.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
   localparam int LANES = 4;

   typedef enum logic [1:0] {
      SZ_LONG = 2'b00,
      SZ_HALF = 2'b01,
      SZ_BYTE = 2'b10,
      SZ_ALT  = 2'b11
   } size_e;

   typedef enum logic [1:0] {
      SW_NONE   = 2'b00,
      SW_REV    = 2'b01,
      SW_HALVES = 2'b10,
      SW_PAIRS  = 2'b11
   } swap_e;

   typedef struct packed {
      size_e size;
      logic  big;
      swap_e swap;
   } cfg_t;

   // index of the last part of a word for a given width
   function automatic logic [1:0] parts_m1(size_e s);
      case (s)
         SZ_BYTE: return 2'd3;
         SZ_HALF: return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

   // lane index xor mask that realises each reorder mode
   function automatic logic [1:0] lane_mask(swap_e m);
      case (m)
         SW_REV:    return 2'd3;
         SW_HALVES: return 2'd2;
         SW_PAIRS:  return 2'd1;
         default:   return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/pwa_swap.sv
module pwa_swap import pwa_pkg::*; #(
   parameter int LANE_W = 9
) (
   input  logic [LANES*LANE_W-1:0] word_in,
   input  swap_e                   mode,
   output logic [LANES*LANE_W-1:0] word_out
);
   logic [LANE_W-1:0] in_l [LANES];
   logic [1:0]        mask;

   assign mask = lane_mask(mode);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign in_l[g] = word_in[g*LANE_W +: LANE_W];
      assign word_out[g*LANE_W +: LANE_W] = in_l[2'(g) ^ mask];
   end
endmodule

// File: rtl/pwa_framer.sv
module pwa_framer import pwa_pkg::*; (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  cfg_t       cfg_live,
   output cfg_t       cfg_eff,
   output logic [1:0] slot,
   output logic       last
);
   logic [1:0] cnt_q;
   cfg_t       cfg_q;
   logic [1:0] top_idx;

   // live controls apply on the first part, the held copy afterwards
   assign cfg_eff = (cnt_q == 2'd0) ? cfg_live : cfg_q;
   assign top_idx = parts_m1(cfg_eff.size);
   assign last    = (cnt_q == top_idx);
   assign slot    = cfg_eff.big ? (top_idx - cnt_q) : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cfg_q <= '0;
      end else if (en) begin
         cnt_q <= last ? 2'd0 : 2'(cnt_q + 2'd1);
         if (cnt_q == 2'd0) cfg_q <= cfg_live;
      end
   end

   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= top_idx);
   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (en && last) |=> (cnt_q == 2'd0));
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt_q));
   a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != 2'd0) |-> (cfg_eff == $past(cfg_eff)));
endmodule

// File: rtl/pwa_wr_pack.sv
module pwa_wr_pack import pwa_pkg::*; #(
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  cfg_t                    cfg_live,
   input  logic                    wr_en,
   input  logic [LANES*LANE_W-1:0] wr_data,
   output logic                    pk_valid,
   output logic [LANES*LANE_W-1:0] pk_word
);
   localparam int WORD_W = LANES*LANE_W;

   cfg_t              cfg_eff;
   logic [1:0]        slot;
   logic              last;
   logic [WORD_W-1:0] asm_q, asm_nxt, asm_sw;

   pwa_framer u_frame (
      .clk(clk), .rst_n(rst_n), .en(wr_en), .cfg_live(cfg_live),
      .cfg_eff(cfg_eff), .slot(slot), .last(last)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [1:0] GI = 2'(g);
      logic              hit;
      logic [LANE_W-1:0] src;
      always_comb begin
         case (cfg_eff.size)
            SZ_BYTE: begin
               hit = (slot == GI);
               src = wr_data[LANE_W-1:0];
            end
            SZ_HALF: begin
               hit = (slot[0] == GI[1]);
               src = wr_data[(g%2)*LANE_W +: LANE_W];
            end
            default: begin
               hit = 1'b1;
               src = wr_data[g*LANE_W +: LANE_W];
            end
         endcase
      end
      assign asm_nxt[g*LANE_W +: LANE_W] =
         (wr_en && hit) ? src : asm_q[g*LANE_W +: LANE_W];
   end

   pwa_swap #(.LANE_W(LANE_W)) u_swap (
      .word_in(asm_nxt), .mode(cfg_eff.swap), .word_out(asm_sw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asm_q    <= '0;
         pk_valid <= 1'b0;
         pk_word  <= '0;
      end else begin
         pk_valid <= wr_en && last;
         if (wr_en) asm_q <= asm_nxt;
         if (wr_en && last) pk_word <= asm_sw;
      end
   end

   a_r6_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
      pk_valid |-> $past(wr_en));
   a_r6_word_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !pk_valid |-> $stable(pk_word));
endmodule

// File: rtl/pwa_rd_unpack.sv
module pwa_rd_unpack import pwa_pkg::*; #(
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  cfg_t                    cfg_live,
   input  logic                    rd_en,
   input  logic [LANES*LANE_W-1:0] rd_word,
   output logic [LANES*LANE_W-1:0] rd_data,
   output logic                    rd_next
);
   localparam int WORD_W = LANES*LANE_W;

   cfg_t              cfg_eff;
   logic [1:0]        slot;
   logic              last;
   logic [WORD_W-1:0] rd_sw;
   logic [LANE_W-1:0] sw_l [LANES];

   pwa_framer u_frame (
      .clk(clk), .rst_n(rst_n), .en(rd_en), .cfg_live(cfg_live),
      .cfg_eff(cfg_eff), .slot(slot), .last(last)
   );

   pwa_swap #(.LANE_W(LANE_W)) u_swap (
      .word_in(rd_word), .mode(cfg_eff.swap), .word_out(rd_sw)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign sw_l[g] = rd_sw[g*LANE_W +: LANE_W];
   end

   always_comb begin
      rd_data = '0;
      case (cfg_eff.size)
         SZ_BYTE: rd_data[LANE_W-1:0] = sw_l[slot];
         SZ_HALF: rd_data[2*LANE_W-1:0] =
            {sw_l[{slot[0], 1'b1}], sw_l[{slot[0], 1'b0}]};
         default: rd_data = rd_sw;
      endcase
   end

   assign rd_next = rd_en && last;

   a_r8_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_eff.size == SZ_BYTE) |-> (rd_data[WORD_W-1:LANE_W] == '0));
   a_r8_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_eff.size == SZ_HALF) |-> (rd_data[WORD_W-1:2*LANE_W] == '0));
endmodule

// File: rtl/port_width_adapter.sv
module port_width_adapter import pwa_pkg::*; #(
   parameter int LANE_W = 9,
   localparam int WORD_W = LANES*LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_size,
   input  logic              cfg_big,
   input  logic [1:0]        cfg_swap,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              pk_valid,
   output logic [WORD_W-1:0] pk_word,
   input  logic [WORD_W-1:0] rd_word,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_next
);
   if (LANE_W < 2) begin : g_bad_lane
      $error("port_width_adapter: LANE_W must be at least 2");
   end

   cfg_t cfg_live;
   assign cfg_live.size = size_e'(cfg_size);
   assign cfg_live.big  = cfg_big;
   assign cfg_live.swap = swap_e'(cfg_swap);

   pwa_wr_pack #(.LANE_W(LANE_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .cfg_live(cfg_live),
      .wr_en(wr_en), .wr_data(wr_data),
      .pk_valid(pk_valid), .pk_word(pk_word)
   );

   pwa_rd_unpack #(.LANE_W(LANE_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .cfg_live(cfg_live),
      .rd_en(rd_en), .rd_word(rd_word),
      .rd_data(rd_data), .rd_next(rd_next)
   );

   a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !pk_valid);
endmodule

// File: tb/port_width_adapter_test.sv
module port_width_adapter_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_size = 2'b00;
   logic        cfg_big = 1'b0;
   logic [1:0]  cfg_swap = 2'b00;
   logic        wr_en = 1'b0;
   logic [35:0] wr_data = '0;
   logic        pk_valid;
   logic [35:0] pk_word;
   logic [35:0] rd_word = '0;
   logic        rd_en = 1'b0;
   logic [35:0] rd_data;
   logic        rd_next;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [35:0] JUNK = 36'hA5C3_96E1_7;

   always #10 clk = ~clk;

   port_width_adapter uut (
      .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_big(cfg_big),
      .cfg_swap(cfg_swap), .wr_en(wr_en), .wr_data(wr_data),
      .pk_valid(pk_valid), .pk_word(pk_word), .rd_word(rd_word),
      .rd_en(rd_en), .rd_data(rd_data), .rd_next(rd_next)
   );

   task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [35:0] swapm(logic [35:0] w, int m);
      logic [8:0] b3, b2, b1, b0;
      {b3, b2, b1, b0} = w;
      case (m)
         1: return {b0, b1, b2, b3};
         2: return {b1, b0, b3, b2};
         3: return {b2, b3, b0, b1};
         default: return w;
      endcase
   endfunction

   function automatic int nparts(int sz);
      return (sz == 2) ? 4 : (sz == 1) ? 2 : 1;
   endfunction

   function automatic logic [35:0] part(logic [35:0] p, int sz, int big, int k);
      int pos;
      pos = big ? nparts(sz) - 1 - k : k;
      if (sz == 2) return {27'd0, p[pos*9 +: 9]};
      if (sz == 1) return {18'd0, p[pos*18 +: 18]};
      return p;
   endfunction

   function automatic logic [35:0] mkword(int seed);
      logic [35:0] w;
      for (int j = 0; j < 4; j++) w[j*9 +: 9] = 9'((seed * 4 + j) * 13 + 7);
      return w;
   endfunction

   task automatic drive_cfg(int sz, int big, int sw);
      cfg_size = 2'(sz);
      cfg_big  = big[0];
      cfg_swap = 2'(sw);
   endtask

   task automatic do_write(int sz, int big, int sw, logic [35:0] iw,
                           bit gap, bit scram, string tg);
      logic [35:0] p;
      logic [35:0] upper;
      int n;
      p = swapm(iw, sw);
      n = nparts(sz);
      upper = (sz == 2) ? ~36'h1FF : (sz == 1) ? ~36'h3FFFF : 36'h0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (k > 0) chk("R6 early strobe", {35'd0, pk_valid}, 36'd0);
         if (k > 0 && scram) drive_cfg((sz + 1) % 3, 1 - big, 3 - sw);
         else drive_cfg(sz, big, sw);
         wr_en = 1'b1;
         wr_data = part(p, sz, big, k) | (upper & JUNK);
         if (gap && k < n - 1) begin
            @(negedge clk);
            wr_en = 1'b0;
            wr_data = JUNK;
            chk("R6 idle strobe", {35'd0, pk_valid}, 36'd0);
         end
      end
      @(negedge clk);
      wr_en = 1'b0;
      drive_cfg(sz, big, sw);
      chk("R6 strobe", {35'd0, pk_valid}, 36'd1);
      chk(tg, pk_word, iw);
   endtask

   task automatic do_read(int sz, int big, int sw, logic [35:0] iw,
                          bit gap, bit scram, string tg);
      logic [35:0] p;
      int n;
      p = swapm(iw, sw);
      n = nparts(sz);
      rd_word = iw;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (k > 0 && scram) drive_cfg((sz + 1) % 3, 1 - big, 3 - sw);
         else drive_cfg(sz, big, sw);
         rd_en = 1'b1;
         #1;
         chk(tg, rd_data, part(p, sz, big, k));
         chk("R6 next", {35'd0, rd_next}, {35'd0, k == n - 1});
         if (sz == 2) chk("R8 upper zero", {9'd0, rd_data[35:9]}, 36'd0);
         if (gap && k < n - 1) begin
            @(negedge clk);
            rd_en = 1'b0;
            #1;
            chk("R6 idle next", {35'd0, rd_next}, 36'd0);
            chk("R6 idle hold", rd_data, part(p, sz, big, k + 1));
         end
      end
      @(negedge clk);
      rd_en = 1'b0;
      drive_cfg(sz, big, sw);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      string tg;
      logic [35:0] w;
      repeat (3) @(negedge clk);
      chk("R1 reset strobe", {35'd0, pk_valid}, 36'd0);
      chk("R1 reset word", pk_word, 36'd0);
      chk("R1 reset next", {35'd0, rd_next}, 36'd0);
      rst_n = 1'b1;
      // first read after reset starts at part 0: byte mode, big endian -> L3
      @(negedge clk);
      w = mkword(1000);
      rd_word = w;
      drive_cfg(2, 1, 0);
      #1;
      chk("R1 first part", rd_data, {27'd0, w[35:27]});
      drive_cfg(0, 0, 0);

      for (int sz = 0; sz < 4; sz++)
         for (int big = 0; big < 2; big++)
            for (int sw = 0; sw < 4; sw++)
               for (int r = 0; r < 2; r++) begin
                  bit scram;
                  scram = (r == 1) && (sz == 1 || sz == 2);
                  w = mkword(sz * 64 + big * 32 + sw * 8 + r);
                  tg = scram ? "R7 held cfg" : (sw != 0) ? "R5 swap" :
                       (sz == 2) ? "R4 byte order" : (sz == 1) ? "R3 half order" :
                       "R2 long word";
                  do_write(sz, big, sw, w, r == 1, scram, tg);
                  do_read(sz, big, sw, w, r == 1, scram, tg);
               end

      // junk on unused inbound bits in both narrow sizes
      do_write(2, 0, 2, mkword(777), 1'b0, 1'b0, "R9 byte ignore upper");
      do_write(1, 1, 3, mkword(778), 1'b0, 1'b0, "R9 half ignore upper");
      // back-to-back long words: a strobe per transfer
      @(negedge clk);
      drive_cfg(0, 0, 1);
      wr_en = 1'b1;
      wr_data = mkword(5);
      @(negedge clk);
      chk("R2 strobe 1", {35'd0, pk_valid}, 36'd1);
      chk("R2 word 1", pk_word, swapm(mkword(5), 1));
      wr_data = mkword(6);
      @(negedge clk);
      wr_en = 1'b0;
      chk("R2 strobe 2", {35'd0, pk_valid}, 36'd1);
      chk("R2 word 2", pk_word, swapm(mkword(6), 1));
      @(negedge clk);
      chk("R6 single pulse", {35'd0, pk_valid}, 36'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule